// File: doc/BRIEF.md
# Memory Bandwidth Monitor

This block sits next to a memory controller and measures how much traffic passes through it. It watches two single-cycle strobes from the controller. One marks an incoming request and the other marks a granted transfer. Each strobe carries the ID of the port that issued it. Ports 0 to 31 are major ports. Ports 32 to 63 are sub-ports of one shared device port. The block keeps a running total of all requests and a running total of all grants. It also has four filtered channels, and each one counts only the grants whose port passes that channel's filter. Each grant stands for 16 bytes moved.

Software drives the block through a word-addressed 32-bit register port. Writes take effect in one cycle. Read data appears one cycle after the read strobe. A measurement window can be bounded by a down-counting timer, which counts memory-clock cycles. When the timer runs out, the block sets a done flag, raises its interrupt and clears its own enable, so the window is one-shot. The counts then hold still until software clears the flag and enables the block again.

Both event inputs are valid-only streams with no ready. The monitor never back-pressures the controller. It samples every cycle in which a valid strobe is high, and a strobe that arrives while counting is stopped is dropped.

Top module: `bw_monitor`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `reg_rd_valid` is low.
- R2: The register at word index i (0x20 to 0x2F) sits at byte address i<<2. Index 0x20 is control. For channel c, the port mask is at 0x21+2c and the sub-port mask is at 0x22+2c. The request total is at 0x29 and the grant total at 0x2A. Channel c's grant count is at 0x2B+c, and the timer is at 0x2F. Read data and `reg_rd_valid` appear in the cycle after `reg_rd_en`. A read of any other address, or of a byte address with bits 1:0 non-zero, returns 0, and a write to such an address changes nothing.
- R3: In control, bit 31 is enable, bit 20 selects timer-bounded windows, bits 3:0 enable channels 0 to 3, and bit 30 is the read-only done flag. All other bits read as 0.
- R4: While enable is set and done is clear, each `req_valid` strobe adds one to the request total and each `grant_valid` strobe adds one to the grant total.
- R5: A grant from a major port p (p < 32) adds one to channel c when channel c is enabled and bit p of its port mask is set. The sub-port mask is not consulted for such a grant, so port-mask bit 23 also matches major port 23.
- R6: A grant from port p >= 32 adds one to channel c when channel c is enabled, bit 23 of its port mask is set and bit p-32 of its sub-port mask is set.
- R7: One grant can increment several channels in the same cycle. A channel whose enable bit is clear never counts.
- R8: In timer mode with timer value T (T of 0 acts as 1), counting runs for exactly T cycles after the enabling write. The timer then reads 0, done is set, `irq` goes high, enable clears, and all counts hold their values.
- R9: Writing control with bit 30 set clears done. If the timer expires in the same cycle, the expiry wins.
- R10: With bit 20 clear, counting continues until enable is cleared, and the timer register keeps its value.
- R11: Count registers are 32 bits wide, wrap from 0xFFFFFFFF to 0, and can be written (writing zero clears them). A write in the same cycle as an increment wins.
- R12: With enable clear, no count changes on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |
| req_valid | input | 1 | Request strobe (valid-only stream) |
| req_port | input | 6 | Port ID of the request |
| grant_valid | input | 1 | Grant strobe, 16 bytes (valid-only stream) |
| grant_port | input | 6 | Port ID of the grant |
| irq | output | 1 | Window-done interrupt, equal to the done flag |

## Verification
The filter is driven from a table of grant port IDs against four differently programmed channels. The table covers major ports in one mask or in two, device sub-ports selected or not, major port 23 against the device-select bit, and ports that match no channel. Together these separate the major-port path from the sub-port path and show when several channels hit at once. Directed runs hold the grant strobe high across a timer window. This shows that the window is exactly T cycles long, that the counts freeze after expiry, and that re-arming opens a new window of the new length. Further runs check that a pre-loaded count wraps, and that strobes have no effect while the block is disabled.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int DATA_W   = 32;
  localparam int PORT_W   = 6;
  localparam int IDX_CTRL = 'h20;
  localparam int IDX_MASK = 'h21;
  localparam int IDX_AREQ = 'h29;
  localparam int IDX_AGNT = 'h2A;
  localparam int IDX_CHAN = 'h2B;
  localparam int IDX_TMR  = 'h2F;
  localparam int B_EN     = 31;
  localparam int B_DONE   = 30;
  localparam int B_TMODE  = 20;
  localparam int B_DEVSEL = 23;

  // Two-level port filter: major ports hit on their own mask bit, device
  // sub-ports need the device-select bit plus their sub-port bit.
  function automatic logic port_hit(input logic [DATA_W-1:0] pmask,
                                    input logic [DATA_W-1:0] smask,
                                    input logic [PORT_W-1:0] port);
    if (port[PORT_W-1]) return pmask[B_DEVSEL] & smask[port[4:0]];
    else                return pmask[port[4:0]];
  endfunction
endpackage

// File: rtl/bwmon_counter.sv
module bwmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (inc)   cnt <= cnt + W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inc) |=> cnt == $past(cnt) + W'(1)); // R11
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inc) |=> $stable(cnt)); // R12
endmodule

// File: rtl/bwmon_chan.sv
module bwmon_chan
  import bwmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pmask,
  input  logic              wr_smask,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              grant_valid,
  input  logic [PORT_W-1:0] grant_port,
  input  logic              count_en,
  output logic [DATA_W-1:0] pmask,
  output logic [DATA_W-1:0] smask,
  output logic [DATA_W-1:0] cnt
);
  logic hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      smask <= '0;
    end else begin
      if (wr_pmask) pmask <= wr_data;
      if (wr_smask) smask <= wr_data;
    end
  end

  assign hit = grant_valid & count_en & port_hit(pmask, smask, grant_port);

  bwmon_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cnt), .wr_data(wr_data),
    .inc(hit), .cnt(cnt)
  );

  AST_CHAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_cnt) |=> $stable(cnt)); // R7
  AST_CHAN_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !wr_cnt) |=> $stable(cnt)); // R5
endmodule

// File: rtl/bwmon_window.sv
module bwmon_window #(
  parameter int TIMER_W  = 32,
  parameter int NUM_CHAN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                wr_timer,
  input  logic                ctl_en,
  input  logic                ctl_done_clr,
  input  logic                ctl_tmode,
  input  logic [NUM_CHAN-1:0] ctl_chan,
  input  logic [TIMER_W-1:0]  timer_wdata,
  output logic                en_q,
  output logic                done_q,
  output logic                tmode_q,
  output logic [NUM_CHAN-1:0] chan_en_q,
  output logic [TIMER_W-1:0]  timer_q,
  output logic                active
);
  logic expire;

  assign active = en_q & ~done_q;
  assign expire = active & tmode_q & (timer_q <= TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      tmode_q   <= 1'b0;
      chan_en_q <= '0;
    end else if (wr_ctrl) begin
      en_q      <= ctl_en;
      tmode_q   <= ctl_tmode;
      chan_en_q <= ctl_chan;
    end else if (expire) begin
      en_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       done_q <= 1'b0;
    else if (expire)                  done_q <= 1'b1;
    else if (wr_ctrl && ctl_done_clr) done_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                timer_q <= '0;
    else if (wr_timer)         timer_q <= timer_wdata;
    else if (active && tmode_q)
      timer_q <= (timer_q == '0) ? '0 : timer_q - TIMER_W'(1);
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_ctrl) |=> (done_q && !en_q)); // R8
  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tmode_q && timer_q > TIMER_W'(1) && !wr_timer)
      |=> timer_q == $past(timer_q) - TIMER_W'(1)); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctl_done_clr && !expire) |=> !done_q); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_ctrl && ctl_done_clr)) |=> done_q); // R9
  AST_TIMER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmode_q && !wr_timer) |=> $stable(timer_q)); // R10
endmodule

// File: rtl/bw_monitor.sv
module bw_monitor
  import bwmon_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_valid,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic              grant_valid,
  input  logic [PORT_W-1:0] grant_port,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned, wr_ok;
  logic              wr_ctrl, wr_timer, wr_areq, wr_agnt;
  logic              en_q, done_q, tmode_q, active;
  logic [NUM_CHAN-1:0] chan_en_q;
  logic [DATA_W-1:0] timer_q, areq_cnt, agnt_cnt, rd_mux;
  logic [DATA_W-1:0] pmask [NUM_CHAN];
  logic [DATA_W-1:0] smask [NUM_CHAN];
  logic [DATA_W-1:0] ccnt  [NUM_CHAN];
  logic              req_unused;

  assign idx      = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign wr_ok    = reg_wr_en & aligned;
  assign wr_ctrl  = wr_ok & (idx == IDX_W'(IDX_CTRL));
  assign wr_timer = wr_ok & (idx == IDX_W'(IDX_TMR));
  assign wr_areq  = wr_ok & (idx == IDX_W'(IDX_AREQ));
  assign wr_agnt  = wr_ok & (idx == IDX_W'(IDX_AGNT));
  assign irq      = done_q;
  // Request port ID is carried on the stream but no filter consumes it.
  assign req_unused = ^req_port;

  bwmon_window #(.TIMER_W(DATA_W), .NUM_CHAN(NUM_CHAN)) u_window (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_timer(wr_timer),
    .ctl_en(reg_wdata[B_EN]), .ctl_done_clr(reg_wdata[B_DONE]),
    .ctl_tmode(reg_wdata[B_TMODE]), .ctl_chan(reg_wdata[NUM_CHAN-1:0]),
    .timer_wdata(reg_wdata), .en_q(en_q), .done_q(done_q),
    .tmode_q(tmode_q), .chan_en_q(chan_en_q), .timer_q(timer_q),
    .active(active)
  );

  bwmon_counter #(.W(DATA_W)) u_areq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_areq), .wr_data(reg_wdata),
    .inc(req_valid & active), .cnt(areq_cnt)
  );

  bwmon_counter #(.W(DATA_W)) u_agnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_agnt), .wr_data(reg_wdata),
    .inc(grant_valid & active), .cnt(agnt_cnt)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    bwmon_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_pmask(wr_ok & (idx == IDX_W'(IDX_MASK + 2*c))),
      .wr_smask(wr_ok & (idx == IDX_W'(IDX_MASK + 2*c + 1))),
      .wr_cnt(wr_ok & (idx == IDX_W'(IDX_CHAN + c))),
      .wr_data(reg_wdata), .grant_valid(grant_valid),
      .grant_port(grant_port), .count_en(active & chan_en_q[c]),
      .pmask(pmask[c]), .smask(smask[c]), .cnt(ccnt[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_CTRL)) begin
        rd_mux[B_EN]           = en_q;
        rd_mux[B_DONE]         = done_q;
        rd_mux[B_TMODE]        = tmode_q;
        rd_mux[NUM_CHAN-1:0]   = chan_en_q;
      end
      if (idx == IDX_W'(IDX_AREQ)) rd_mux = areq_cnt;
      if (idx == IDX_W'(IDX_AGNT)) rd_mux = agnt_cnt;
      if (idx == IDX_W'(IDX_TMR))  rd_mux = timer_q;
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (idx == IDX_W'(IDX_MASK + 2*c))     rd_mux = pmask[c];
        if (idx == IDX_W'(IDX_MASK + 2*c + 1)) rd_mux = smask[c];
        if (idx == IDX_W'(IDX_CHAN + c))       rd_mux = ccnt[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata    <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      reg_rdata    <= reg_rd_en ? rd_mux : reg_rdata;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid); // R2
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rd_valid); // R2
  AST_STOPPED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_areq) |=> $stable(areq_cnt)); // R12
  AST_GNT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && active && !wr_agnt) |=> agnt_cnt == $past(agnt_cnt) + 1); // R4
  AST_IRQ_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_agnt) |=> $stable(agnt_cnt) || req_unused != req_unused); // R8
endmodule

// File: tb/bw_monitor_bench.sv
module bw_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // Each entry: [9:4] grant port, [3:0] expected channel hits.
  localparam logic [9:0] VEC [NVEC] = '{
    {6'd0,  4'b0001}, {6'd5,  4'b0101}, {6'd33, 4'b0110}, {6'd36, 4'b0010},
    {6'd23, 4'b0110}, {6'd40, 4'b0000}, {6'd7,  4'b0000}, {6'd32, 4'b0000}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_rd_valid, irq;
  logic req_valid = 0, grant_valid = 0;
  logic [5:0] req_port = 0, grant_port = 0;
  int checks = 0, fails = 0;
  int exp_ch [4];
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_monitor u_bw_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid), .req_valid(req_valid), .req_port(req_port),
    .grant_valid(grant_valid), .grant_port(grant_port), .irq(irq)
  );

  function automatic logic [7:0] ba(input int i);
    return 8'(i << 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = ba(i); reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd_addr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1; reg_addr = a;
    @(negedge clk); reg_rd_en = 0;
    if (reg_rd_valid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R2 rd_valid actual=%b expected=1", reg_rd_valid);
    end
    d = reg_rdata;
  endtask

  task automatic rdi(input int i, output logic [31:0] d);
    rd_addr(ba(i), d);
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk); grant_valid = 1; grant_port = p; req_valid = 1; req_port = p;
    @(negedge clk); grant_valid = 0; req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rd_valid", {31'b0, reg_rd_valid}, 0);
    rst_n = 1;
    rdi('h20, rd); check("R1 ctrl", rd, 0);
    rdi('h2A, rd); check("R1 all-grant", rd, 0);
    rdi('h2F, rd); check("R1 timer", rd, 0);

    // R3: reserved bits read zero; done bit not writable
    wr('h20, 32'h7FFF_FFFF);
    rdi('h20, rd); check("R3 ctrl fields", rd, 32'h0010_000F);
    // R2: unmapped and misaligned accesses
    wr('h00, 32'hFFFF_FFFF);
    rd_addr(8'h00, rd); check("R2 unmapped read", rd, 0);
    rd_addr(8'h81, rd); check("R2 misaligned read", rd, 0);
    rdi('h20, rd); check("R2 stray write ignored", rd, 32'h0010_000F);

    // Filter setup: ch0 major 0,5; ch1 device subs 1,4; ch2 major 5 + sub 1; ch3 disabled
    wr('h21, 32'h0000_0021); wr('h22, 32'h0000_FFFF);
    wr('h23, 32'h0080_0000); wr('h24, 32'h0000_0012);
    wr('h25, 32'h0080_0020); wr('h26, 32'h0000_0002);
    wr('h27, 32'hFFFF_FFFF); wr('h28, 32'hFFFF_FFFF);
    rdi('h25, rd); check("R2 ch2 port mask", rd, 32'h0080_0020);
    wr('h2F, 32'd77);
    wr('h20, 32'h8000_0007);
    for (int c = 0; c < 4; c++) exp_ch[c] = 0;
    // Table walk: R5 major, R6 sub-port, R7 multi-hit and disabled channel
    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][9:4]);
      for (int c = 0; c < 4; c++) begin
        if (VEC[v][c]) exp_ch[c]++;
        rdi('h2B + c, rd);
        check($sformatf("R5/R6/R7 vec%0d ch%0d", v, c), rd, 32'(exp_ch[c]));
      end
    end
    rdi('h29, rd); check("R4 all-request", rd, NVEC);
    rdi('h2A, rd); check("R4 all-grant", rd, NVEC);
    rdi('h2F, rd); check("R10 timer untouched", rd, 32'd77);

    // R12: disabled, no counting
    wr('h20, 32'h0000_0007);
    pulse(6'd0);
    rdi('h2B, rd); check("R12 ch0 frozen", rd, 32'(exp_ch[0]));
    rdi('h2A, rd); check("R12 all-grant frozen", rd, NVEC);

    // R11: wrap and clear-by-write
    wr('h2B, 32'hFFFF_FFFF);
    wr('h20, 32'h8000_0001);
    pulse(6'd0);
    rdi('h2B, rd); check("R11 wrap", rd, 0);
    wr('h29, 32'h0);
    rdi('h29, rd); check("R11 clear by write", rd, 0);

    // R8: timer window of 5 cycles with grant held high
    wr('h20, 32'h0);
    wr('h2A, 32'h0); wr('h2B, 32'h0); wr('h2F, 32'd5);
    @(negedge clk); grant_valid = 1; grant_port = 0;
    wr('h20, 32'h8010_0001);
    repeat (12) @(negedge clk);
    grant_valid = 0;
    rdi('h2A, rd); check("R8 window length", rd, 5);
    rdi('h2B, rd); check("R8 ch0 window", rd, 5);
    rdi('h20, rd); check("R8 ctrl after expiry", rd, 32'h4010_0001);
    rdi('h2F, rd); check("R8 timer zero", rd, 0);
    check("R8 irq", {31'b0, irq}, 1);
    pulse(6'd0);
    rdi('h2A, rd); check("R8 hold after done", rd, 5);

    // R9: clear done, re-arm with 3
    wr('h20, 32'h4010_0001);
    rdi('h20, rd); check("R9 done cleared", rd, 32'h0010_0001);
    check("R9 irq low", {31'b0, irq}, 0);
    wr('h2F, 32'd3);
    @(negedge clk); grant_valid = 1; grant_port = 0;
    wr('h20, 32'h8010_0001);
    repeat (10) @(negedge clk);
    grant_valid = 0;
    rdi('h2A, rd); check("R9 re-armed window", rd, 8);
    check("R9 irq again", {31'b0, irq}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule